// File: doc/BRIEF.md
# Ethernet PHY LED Controller

This block turns the status of a tri-speed Ethernet PHY into drive levels for a row of LEDs. Every LED owns two 8-bit configuration words. One word chooses the condition that lights the LED steadily and the condition that makes it blink fast. The other word chooses the condition for slow blinking and a mask of traffic events. A selected event blanks the LED for a short stretch, which gives the usual activity flicker. Two shared words hold the fast and slow blink rates and two 3-bit codes. Each code is decoded against the PHY status into a flag for logic outside the block. Configuration goes through a plain synchronous write/read port whose registers are 16 bits wide.

Every blink waveform comes from one free-running prescaler that is sized by a clock-frequency parameter and ticks 32 times a second. A second prescaler gives a millisecond tick, which the traffic stretch counters use. A new rate selection is held back until the waveform it replaces reaches a half-period edge, so an LED never shows a sliver pulse.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the words read as follows: address 0 = 0x00C5 (shared rates), address 1 = 0x0067 (shared complex codes), addresses 2..9 hold the LED high/low pairs 0x0070/0x0003, 0x0020/0x0000, 0x0040/0x0000, 0x0040/0x0020 for LED0..LED3 (LED i high at 2+2i, low at 3+2i).
- R2: Bits 15:8 of every word read as zero and writes to them are dropped. Addresses above the last LED word read as zero, and writes to them change no word.
- R3: A 4-bit condition code is true as follows. 1 = link up at 10 Mbit/s, 2 = link up at 100, 3 = link up at 10 or 100, 4 = link up at 1000, 5 = link up at 10 or 1000, 6 = link up at 100 or 1000, 7 = link up at any speed, 8 = powered down, 9 = energy-saving mode, 10 = auto-negotiation, 11 = analog self-test, 12 = cable diagnostics. Codes 0 and 13..15 are never true. Speed input: 0 = 10, 1 = 100, 2 = 1000, 3 = no speed.
- R4: LED high bits 7:4 give the steady-on condition. When it is the only active source, the LED is on exactly while the condition holds.
- R5: LED high bits 3:0 give the fast-blink condition. The LED then follows the fast waveform, whose rate is set by address 0 bits 7:6 (0 = 2 Hz, 1 = 4 Hz, 2 = 8 Hz, 3 = 16 Hz).
- R6: LED low bits 7:4 give the slow-blink condition. The LED then follows the slow waveform, whose rate is set by address 0 bits 5:4 with the same encoding.
- R7: Priority from highest to lowest: an active traffic stretch forces the LED off, then fast blink, then slow blink, then steady-on, otherwise off.
- R8: LED low bits 3:0 are an event mask: bit 0 transmit, bit 1 receive, bit 2 collision, bit 3 no effect. A selected strobe starts a stretch of PULSE_MS millisecond ticks (between PULSE_MS-1 and PULSE_MS ms). Strobes that are not selected have no effect.
- R9: A selected strobe during a stretch restarts the stretch at its full length.
- R10: Blink waveforms have 50% duty, change only on 1/32-second ticks, and all derive from one counter. From reset, a waveform at rate code c equals bit (3-c) of the count of 1/32 s ticks. A new rate code takes effect at the next half-period edge of the current waveform.
- R11: Address 1 bits 6:4 (scan) and bits 2:0 (blink) take 3-bit codes: 0 = none, 1 = link up, 2 = powered down, 3 = energy-saving, 4 = auto-negotiation, 5 = self-test, 6 = cable diagnostics, 7 = test mode. Each flag output is high exactly while its code's status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Write strobe for the configuration port |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| link_up_i | input | 1 | Link is up |
| link_speed_i | input | 2 | Speed code: 0 = 10, 1 = 100, 2 = 1000, 3 = none |
| pdown_i | input | 1 | PHY powered down |
| eee_i | input | 1 | Energy-saving mode active |
| aneg_i | input | 1 | Auto-negotiation running |
| abist_i | input | 1 | Analog self-test running |
| cdiag_i | input | 1 | Cable diagnostics running |
| test_i | input | 1 | Test mode running |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| col_i | input | 1 | Collision strobe |
| led_o | output | NUM_LEDS | LED drive, 1 = lit (registered) |
| cplx_scan_o | output | 1 | Scan-code enable flag |
| cplx_blink_o | output | 1 | Blink-code enable flag |

## Verification
The assertions take every status input and strobe to be synchronous to clk. They also take it that the stretch counter is reloaded only by a strobe whose mask bit is set, so "selected strobe, then stretch active on the next cycle" can be checked from the ports and the mask fields. The stimulus changes inputs only on falling edges and holds each strobe high for exactly one cycle. It samples blink waveforms in the middle of a 1/32-second tick period, so a waveform edge never lands near a sample. Rate selectors are changed only when more than half of the slowest period is left before the next check.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    localparam int WORD_W  = 16;
    localparam int STORE_W = 8;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_NONE = 2'd3
    } speed_e;

    typedef struct packed {
        logic   link_up;
        speed_e speed;
        logic   pdown;
        logic   eee;
        logic   aneg;
        logic   abist;
        logic   cdiag;
        logic   test;
    } phy_status_t;

    typedef struct packed {
        logic [1:0] fast_rate;
        logic [1:0] slow_rate;
        logic [2:0] cscan;
        logic [2:0] cblink;
    } shared_cfg_t;

    typedef struct packed {
        logic [3:0] on_cond;
        logic [3:0] fast_cond;
        logic [3:0] slow_cond;
        logic [3:0] pulse_mask;
    } led_cfg_t;

    // Reset contents of each stored byte, by word address.
    function automatic logic [STORE_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 8'hC5;
            1:       return 8'h67;
            2:       return 8'h70;
            3:       return 8'h03;
            4:       return 8'h20;
            6:       return 8'h40;
            8:       return 8'h40;
            9:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // Codes 1..7 form a speed mask: bit0 = 10, bit1 = 100, bit2 = 1000.
    function automatic logic cond_met(input logic [3:0] code, input phy_status_t st);
        logic hit;
        hit = 1'b0;
        if (code[3] == 1'b0) begin
            if (st.link_up && st.speed != SPD_NONE)
                hit = code[st.speed];
        end else begin
            case (code[2:0])
                3'd0:    hit = st.pdown;
                3'd1:    hit = st.eee;
                3'd2:    hit = st.aneg;
                3'd3:    hit = st.abist;
                3'd4:    hit = st.cdiag;
                default: hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

    function automatic logic cplx_met(input logic [2:0] code, input phy_status_t st);
        case (code)
            3'd1:    return st.link_up;
            3'd2:    return st.pdown;
            3'd3:    return st.eee;
            3'd4:    return st.aneg;
            3'd5:    return st.abist;
            3'd6:    return st.cdiag;
            3'd7:    return st.test;
            default: return 1'b0;
        endcase
    endfunction

    // Rate code to phase-counter bit: 16 Hz is bit 0, 2 Hz is bit 3.
    function automatic logic [1:0] rate_bit(input logic [1:0] code);
        return ~code;
    endfunction

endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs
    import phy_led_pkg::*;
#(
    parameter int NUM_LEDS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    output shared_cfg_t         shared_o,
    output led_cfg_t            led_cfg_o [NUM_LEDS]
);
    localparam int NREGS = 2 + 2 * NUM_LEDS;

    logic [STORE_W-1:0] store_q [NREGS];
    logic [WORD_W-STORE_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = wdata_i[WORD_W-1:STORE_W];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREGS; k++) begin
            if (rst)
                store_q[k] <= reset_value(k);
            else if (wr_i && int'(addr_i) == k)
                store_q[k] <= wdata_i[STORE_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (int'(addr_i) == k)
                rdata_o[STORE_W-1:0] = store_q[k];
        end
    end

    assign shared_o.fast_rate = store_q[0][7:6];
    assign shared_o.slow_rate = store_q[0][5:4];
    assign shared_o.cscan     = store_q[1][6:4];
    assign shared_o.cblink    = store_q[1][2:0];

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_cfg
        assign led_cfg_o[i].on_cond    = store_q[2 + 2*i][7:4];
        assign led_cfg_o[i].fast_cond  = store_q[2 + 2*i][3:0];
        assign led_cfg_o[i].slow_cond  = store_q[3 + 2*i][7:4];
        assign led_cfg_o[i].pulse_mask = store_q[3 + 2*i][3:0];
    end

endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink
    import phy_led_pkg::*;
#(
    parameter int CLK_HZ = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fast_rate_i,
    input  logic [1:0] slow_rate_i,
    output logic       tick32_o,
    output logic       ms_tick_o,
    output logic       fast_o,
    output logic       slow_o
);
    localparam int DIV32  = (CLK_HZ / 32 > 0) ? CLK_HZ / 32 : 1;
    localparam int DIVMS  = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int D32_W  = $clog2(DIV32 + 1);
    localparam int DMS_W  = $clog2(DIVMS + 1);
    localparam logic [1:0] FAST_RST = reset_value(0) >> 6;
    localparam logic [1:0] SLOW_RST = reset_value(0) >> 4;

    logic [D32_W-1:0] div32_q;
    logic [DMS_W-1:0] divms_q;
    logic [3:0]       phase_q;
    logic [3:0]       phase_n;
    logic [1:0]       fsel_q, ssel_q;
    logic             fast_q, slow_q;

    assign tick32_o  = (div32_q == D32_W'(DIV32 - 1));
    assign ms_tick_o = (divms_q == DMS_W'(DIVMS - 1));
    assign phase_n   = phase_q + 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            div32_q <= '0;
            divms_q <= '0;
        end else begin
            div32_q <= tick32_o  ? '0 : div32_q + 1'b1;
            divms_q <= ms_tick_o ? '0 : divms_q + 1'b1;
        end
    end

    // A new selector is taken only where the running waveform has an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            fsel_q  <= FAST_RST;
            ssel_q  <= SLOW_RST;
            fast_q  <= 1'b0;
            slow_q  <= 1'b0;
        end else if (tick32_o) begin
            phase_q <= phase_n;
            if (phase_n[rate_bit(fsel_q)] != phase_q[rate_bit(fsel_q)]) begin
                fsel_q <= fast_rate_i;
                fast_q <= phase_n[rate_bit(fast_rate_i)];
            end
            if (phase_n[rate_bit(ssel_q)] != phase_q[rate_bit(ssel_q)]) begin
                ssel_q <= slow_rate_i;
                slow_q <= phase_n[rate_bit(slow_rate_i)];
            end
        end
    end

    assign fast_o = fast_q;
    assign slow_o = slow_q;

endmodule

// File: rtl/phy_led_lane.sv
module phy_led_lane
    import phy_led_pkg::*;
#(
    parameter int PULSE_MS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  led_cfg_t    cfg_i,
    input  phy_status_t st_i,
    input  logic        tx_i,
    input  logic        rx_i,
    input  logic        col_i,
    input  logic        ms_tick_i,
    input  logic        fast_i,
    input  logic        slow_i,
    output logic        pulse_act_o,
    output logic        led_o
);
    localparam int CNT_W = $clog2(PULSE_MS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             led_d, led_q;

    assign hit         = |(cfg_i.pulse_mask & {1'b0, col_i, rx_i, tx_i});
    assign pulse_act_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (hit)
            cnt_q <= CNT_W'(PULSE_MS);
        else if (ms_tick_i && pulse_act_o)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        if (pulse_act_o)
            led_d = 1'b0;
        else if (cond_met(cfg_i.fast_cond, st_i))
            led_d = fast_i;
        else if (cond_met(cfg_i.slow_cond, st_i))
            led_d = slow_i;
        else
            led_d = cond_met(cfg_i.on_cond, st_i);
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= 1'b0;
        else     led_q <= led_d;
    end

    assign led_o = led_q;

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int NUM_LEDS = 4,
    parameter int CLK_HZ   = 25_000_000,
    parameter int PULSE_MS = 32,
    localparam int ADDR_W  = $clog2(2 * NUM_LEDS + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [15:0]         reg_wdata_i,
    output logic [15:0]         reg_rdata_o,
    input  logic                link_up_i,
    input  logic [1:0]          link_speed_i,
    input  logic                pdown_i,
    input  logic                eee_i,
    input  logic                aneg_i,
    input  logic                abist_i,
    input  logic                cdiag_i,
    input  logic                test_i,
    input  logic                tx_act_i,
    input  logic                rx_act_i,
    input  logic                col_i,
    output logic [NUM_LEDS-1:0] led_o,
    output logic                cplx_scan_o,
    output logic                cplx_blink_o
);
    shared_cfg_t          shared_cfg;
    led_cfg_t             led_cfg [NUM_LEDS];
    phy_status_t          st;
    logic                 tick32, ms_tick, fast_wave, slow_wave;
    logic [NUM_LEDS-1:0]  pulse_act;
    logic [4*NUM_LEDS-1:0] mask_flat;

    assign st.link_up = link_up_i;
    assign st.speed   = speed_e'(link_speed_i);
    assign st.pdown   = pdown_i;
    assign st.eee     = eee_i;
    assign st.aneg    = aneg_i;
    assign st.abist   = abist_i;
    assign st.cdiag   = cdiag_i;
    assign st.test    = test_i;

    phy_led_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .shared_o  (shared_cfg),
        .led_cfg_o (led_cfg)
    );

    phy_led_blink #(.CLK_HZ(CLK_HZ)) u_blink (
        .clk         (clk),
        .rst         (rst),
        .fast_rate_i (shared_cfg.fast_rate),
        .slow_rate_i (shared_cfg.slow_rate),
        .tick32_o    (tick32),
        .ms_tick_o   (ms_tick),
        .fast_o      (fast_wave),
        .slow_o      (slow_wave)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane
        phy_led_lane #(.PULSE_MS(PULSE_MS)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .cfg_i       (led_cfg[i]),
            .st_i        (st),
            .tx_i        (tx_act_i),
            .rx_i        (rx_act_i),
            .col_i       (col_i),
            .ms_tick_i   (ms_tick),
            .fast_i      (fast_wave),
            .slow_i      (slow_wave),
            .pulse_act_o (pulse_act[i]),
            .led_o       (led_o[i])
        );
        assign mask_flat[4*i +: 4] = led_cfg[i].pulse_mask;
    end

    assign cplx_scan_o  = cplx_met(shared_cfg.cscan, st);
    assign cplx_blink_o = cplx_met(shared_cfg.cblink, st);

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk #(
    parameter int NUM_LEDS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick32,
    input logic                  fast_wave,
    input logic                  slow_wave,
    input logic [NUM_LEDS-1:0]   pulse_act,
    input logic [NUM_LEDS-1:0]   led_o,
    input logic [4*NUM_LEDS-1:0] mask_flat,
    input logic                  tx_act_i,
    input logic                  rx_act_i,
    input logic                  col_i,
    input logic [2:0]            scan_code,
    input logic                  cplx_scan_o
);
    AST_FAST_ON_TICK: assert property (@(posedge clk) disable iff (rst) !tick32 |=> $stable(fast_wave)); // R10
    AST_SLOW_ON_TICK: assert property (@(posedge clk) disable iff (rst) !tick32 |=> $stable(slow_wave)); // R10
    AST_SCAN_NONE: assert property (@(posedge clk) disable iff (rst) (scan_code == 3'd0) |-> !cplx_scan_o); // R11

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chk
        AST_STRETCH_DARK: assert property (@(posedge clk) disable iff (rst) pulse_act[i] |=> !led_o[i]); // R7
        AST_STRETCH_START: assert property (@(posedge clk) disable iff (rst)
            ((tx_act_i && mask_flat[4*i]) || (rx_act_i && mask_flat[4*i+1]) || (col_i && mask_flat[4*i+2]))
            |=> pulse_act[i]); // R8
    end
endmodule

bind phy_led_ctrl phy_led_ctrl_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick32      (tick32),
    .fast_wave   (fast_wave),
    .slow_wave   (slow_wave),
    .pulse_act   (pulse_act),
    .led_o       (led_o),
    .mask_flat   (mask_flat),
    .tx_act_i    (tx_act_i),
    .rx_act_i    (rx_act_i),
    .col_i       (col_i),
    .scan_code   (shared_cfg.cscan),
    .cplx_scan_o (cplx_scan_o)
);

// File: tb/phy_led_ctrl_bench.sv
`timescale 1ns/1ps
module phy_led_ctrl_bench;
    localparam int NL   = 4;
    localparam int HZ   = 3200;
    localparam int PMS  = 4;
    localparam int T32  = HZ / 32;
    localparam int TMS  = HZ / 1000;
    localparam int AW   = $clog2(2 * NL + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic link = 0, pd = 0, eee = 0, an = 0, ab = 0, cd = 0, tm = 0;
    logic [1:0] spd = 0;
    logic tx = 0, rx = 0, col = 0;
    logic [NL-1:0] led;
    logic cscan, cblink;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    phy_led_ctrl #(.NUM_LEDS(NL), .CLK_HZ(HZ), .PULSE_MS(PMS)) u_phy_led_ctrl (
        .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .link_up_i(link), .link_speed_i(spd), .pdown_i(pd),
        .eee_i(eee), .aneg_i(an), .abist_i(ab), .cdiag_i(cd), .test_i(tm),
        .tx_act_i(tx), .rx_act_i(rx), .col_i(col), .led_o(led),
        .cplx_scan_o(cscan), .cplx_blink_o(cblink)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = 16'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int a, input int exp);
        addr = AW'(a);
        #1;
        check(tag, int'(rdata), exp);
    endtask

    task automatic set_status(input int p);
        link = 0; spd = 2'd0; pd = 0; eee = 0; an = 0; ab = 0; cd = 0; tm = 0;
        case (p)
            0: begin link = 1; spd = 2'd0; end
            1: begin link = 1; spd = 2'd1; end
            2: begin link = 1; spd = 2'd2; end
            3: begin link = 1; spd = 2'd3; end
            4: spd = 2'd2;
            5: pd = 1;
            6: eee = 1;
            7: an = 1;
            8: ab = 1;
            9: cd = 1;
            default: tm = 1;
        endcase
    endtask

    function automatic int cond_ref(input int code);
        bit s10, s100, s1000;
        s10 = link && spd == 2'd0;
        s100 = link && spd == 2'd1;
        s1000 = link && spd == 2'd2;
        case (code)
            1: return int'(s10);
            2: return int'(s100);
            3: return int'(s10 || s100);
            4: return int'(s1000);
            5: return int'(s10 || s1000);
            6: return int'(s100 || s1000);
            7: return int'(s10 || s100 || s1000);
            8: return int'(pd);
            9: return int'(eee);
            10: return int'(an);
            11: return int'(ab);
            12: return int'(cd);
            default: return 0;
        endcase
    endfunction

    function automatic int cplx_ref(input int code);
        case (code)
            1: return int'(link);
            2: return int'(pd);
            3: return int'(eee);
            4: return int'(an);
            5: return int'(ab);
            6: return int'(cd);
            7: return int'(tm);
            default: return 0;
        endcase
    endfunction

    // Moves to the middle of the next 1/32 s tick period, returns tick count.
    task automatic wait_mid(output int t);
        @(negedge clk);
        while ((n % T32) != T32 / 2) @(negedge clk);
        t = (n / T32) % 16;
    endtask

    task automatic strobe(input bit a, input bit b, input bit c);
        @(negedge clk);
        tx = a; rx = b; col = c;
        @(negedge clk);
        tx = 0; rx = 0; col = 0;
    endtask

    task automatic wave_check(input string tag, input int lane, input int bitpos, input int count);
        int t;
        for (int k = 0; k < count; k++) begin
            wait_mid(t);
            check(tag, int'(led[lane]), (t >> bitpos) & 1);
        end
    endtask

    task automatic settle_ticks(input int ticks);
        repeat (ticks * T32) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int exp_rst [10];
        int t;
        exp_rst = '{'h00C5, 'h0067, 'h0070, 'h0003, 'h0020, 'h0000, 'h0040, 'h0000, 'h0040, 'h0020};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents and idle outputs
        check("R1 led idle", int'(led), 0);
        check("R11 flags idle", int'({cscan, cblink}), 0);
        for (int a = 0; a < 10; a++) rd_check("R1 reset word", a, exp_rst[a]);

        // R2: upper byte dropped, unmapped addresses inert
        wr_reg(5, 'hABCD);
        rd_check("R2 upper byte", 5, 'h00CD);
        wr_reg(12, 'h00FF);
        rd_check("R2 unmapped read", 12, 0);
        rd_check("R2 unmapped write", 9, 'h0020);
        rd_check("R2 neighbour kept", 0, 'h00C5);

        // R3/R4: every steady-on code against every status pattern on LED0
        wr_reg(3, 'h00);
        for (int code = 0; code < 16; code++) begin
            wr_reg(2, code << 4);
            for (int p = 0; p < 11; p++) begin
                @(negedge clk);
                set_status(p);
                repeat (2) @(negedge clk);
                check("R3 R4 steady decode", int'(led[0]), cond_ref(code));
            end
        end

        // R5/R7/R10: LED1 fast over slow over steady, link up at 1000
        set_status(2);
        wr_reg(4, 'h77);
        wr_reg(5, 'h70);
        wave_check("R5 R7 fast 16Hz", 1, 0, 16);
        wr_reg(4, 'h70);
        wave_check("R6 R7 slow 2Hz", 1, 3, 16);
        wr_reg(5, 'h00);
        repeat (2) @(negedge clk);
        check("R4 R7 steady fallback", int'(led[1]), 1);

        // R10: rate change takes effect at an edge, then follows the counter
        wr_reg(0, 'h45);
        wr_reg(4, 'h77);
        settle_ticks(10);
        wave_check("R5 R10 fast 4Hz", 1, 2, 16);
        wr_reg(0, 'h65);
        wr_reg(4, 'h70);
        wr_reg(5, 'h70);
        settle_ticks(10);
        wave_check("R6 R10 slow 8Hz", 1, 1, 16);

        // R8: LED2 steady on any link, transmit only
        wr_reg(6, 'h70);
        wr_reg(7, 'h01);
        repeat (2) @(negedge clk);
        check("R8 lit before strobe", int'(led[2]), 1);
        strobe(0, 1, 0);
        @(negedge clk);
        check("R8 rx ignored", int'(led[2]), 1);
        strobe(0, 0, 1);
        @(negedge clk);
        check("R8 col ignored", int'(led[2]), 1);
        strobe(1, 0, 0);
        repeat ((PMS - 1) * TMS + 1) @(negedge clk);
        check("R8 stretch held", int'(led[2]), 0);
        repeat (TMS) @(negedge clk);
        check("R8 stretch ended", int'(led[2]), 1);
        wr_reg(7, 'h08);
        strobe(1, 1, 1);
        @(negedge clk);
        check("R8 reserved bit inert", int'(led[2]), 1);
        wr_reg(7, 'h06);
        strobe(0, 0, 1);
        @(negedge clk);
        check("R8 col selected", int'(led[2]), 0);
        repeat (PMS * TMS + 2) @(negedge clk);
        strobe(0, 1, 0);
        @(negedge clk);
        check("R8 rx selected", int'(led[2]), 0);
        repeat (PMS * TMS + 2) @(negedge clk);

        // R9: retrigger extends the stretch
        strobe(0, 1, 0);
        repeat (5) @(negedge clk);
        strobe(0, 1, 0);
        repeat ((PMS - 1) * TMS + 1) @(negedge clk);
        check("R9 retrigger held", int'(led[2]), 0);
        repeat (TMS) @(negedge clk);
        check("R9 retrigger ended", int'(led[2]), 1);

        // R7: stretch wins over a fast blink that is currently high
        wr_reg(0, 'hC5);
        wr_reg(6, 'h77);
        settle_ticks(10);
        wait_mid(t);
        while ((t & 1) == 0) wait_mid(t);
        check("R7 fast high before", int'(led[2]), 1);
        strobe(0, 1, 0);
        @(negedge clk);
        check("R7 stretch over fast", int'(led[2]), 0);

        // R11: both complex codes against every status pattern
        for (int code = 0; code < 8; code++) begin
            wr_reg(1, code);
            for (int p = 0; p < 11; p++) begin
                set_status(p);
                #1;
                check("R11 blink flag", int'(cblink), cplx_ref(code));
                check("R11 scan none", int'(cscan), 0);
            end
            wr_reg(1, code << 4);
            for (int p = 0; p < 11; p++) begin
                set_status(p);
                #1;
                check("R11 scan flag", int'(cscan), cplx_ref(code));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule